// File: doc/BRIEF.md
# Paged Register Access Front End for a Dual-Channel Serial Controller

This block sits between an 8-bit processor bus and the two channels of a serial communications controller. Each bus access carries a chip enable, a read or write strobe, a channel select and a port select. A data-port access goes straight to the channel's transmit holding byte (write) or receive byte (read). A control-port access is routed through a register pointer that each channel keeps in its register 0. That pointer is loaded by a control write while it points at register 0. After any access to another register it falls back to register 0.

The low eight register slots are reached directly. The upper eight are reached by a one-shot "bank high" command carried in the same write that loads the pointer. The command adds 8 to the index for exactly one following control access on that channel. Register 9 is shared between the channels and carries channel and device reset commands. Reads of registers 4 and 5 can be switched between status images and stored configuration by a bit in register 7.

The write registers are exported as a flat bus for the serial logic. Receive bytes, status images and the interrupt vector come in from that logic.

Top module: `regptr_top`

## Requirements
- R1: An access is a clock cycle with `cs`=1 and `wr`=1 (write) or `cs`=1, `rd`=1, `wr`=0 (read). `chan_b`=1 selects channel B and 0 selects channel A. `cd_sel`=1 selects the data port and 0 selects the control port. `rdata` is 0 in every cycle that is not a read.
- R2: A control access uses index {bank_high, wr0[2:0]}. A control write at index 0 stores the whole byte in register 0, which is slot 0 on `wregs_o`.
- R3: A control write at index 0 whose bits 5:3 equal 3'b001 sets bank_high. The next control access on that channel, read or write, uses index 8+wr0[2:0]. bank_high is then clear. Data-port accesses and accesses to the other channel leave it pending.
- R4: After a control access at a nonzero index, wr0[2:0] is cleared. If bank_high was used, wr0[3] is cleared as well, so the next control access goes to index 0.
- R5: Control reads return `rr0_i` at index 0 and `rr1_i` at index 1 (the byte for the selected channel). Index 2 returns `vec_i` on channel B and 0 on channel A. Index 13 returns stored register 13. Indices 3, 6, 7, 9, 10, 11, 12, 14 and 15 return 0.
- R6: A read at index 4 or 5 returns stored register 4 or 5 when bit 6 of stored register 7 is 1. Otherwise it returns `rr0_i` or `rr1_i` respectively.
- R7: A control read at index 8 and a data-port read both return the channel's `rx_i` byte. A control write at index 8 and a data-port write both load the channel's `tx_o` byte. Either write raises that channel's `tx_load_o` bit for the one cycle after the write edge. Data-port accesses do not change the pointer.
- R8: Control writes at indices 1 to 7 and 11 to 14 are stored in that channel's slot. Writes at 10 and 15 are discarded, so their slots stay 0.
- R9: A control write at index 9 from either channel stores the byte in the shared `mctl_o` register. Slot 9 of each channel stays 0.
- R10: Bits 7:6 of a register 9 write are a reset command. 2'b00 does nothing. 2'b01 clears channel B's registers, pointer and bank_high. 2'b10 does the same for channel A. 2'b11 does it for both channels and also clears both `tx_o` bytes. `mctl_o` keeps the written byte.
- R11: `rst_n`=0 clears all registers, pointers, bank_high flags, `tx_o`, `tx_load_o` and `mctl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip enable |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| chan_b | input | 1 | Channel select, 1 selects channel B |
| cd_sel | input | 1 | Port select, 1 selects the data port and 0 the control port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational during a read |
| rr0_i | input | 16 | Status image 0 per channel, {B, A} |
| rr1_i | input | 16 | Status image 1 per channel, {B, A} |
| vec_i | input | 8 | Interrupt vector, read at index 2 of channel B |
| rx_i | input | 16 | Receive byte per channel, {B, A} |
| tx_o | output | 16 | Transmit holding byte per channel, {B, A} |
| tx_load_o | output | 2 | One-cycle load pulse per channel, {B, A} |
| wregs_o | output | 256 | Write registers, channel ch slot i at bit ch*128+i*8 |
| mctl_o | output | 8 | Shared register 9 |

## Verification
The bench targets the one-shot nature of the bank-high flag. It checks that a second control access falls back to index 0. A design that kept the flag would read the receive byte twice or write register 8+n again. It also checks that data-port accesses do not consume a pending flag, and that the flag on one channel does not leak to the other. A design that got either wrong would send the later write to a low register.

The mirror switch on registers 4 and 5 is tested in both states. Writes to 10 and 15 are tested for leaving their slots at 0. The reset command is issued from the opposite channel, to show that a design which reset the issuing channel or both channels fails. A device reset is issued while the other channel holds a pending pointer, to show that a design leaving that pointer behind fails.

// File: rtl/regptr_pkg.sv
package regptr_pkg;
    localparam int DW      = 8;
    localparam int NREG    = 16;
    localparam int NCH     = 2;
    localparam int IDXW    = $clog2(NREG);
    localparam int PTRW    = IDXW - 1;
    localparam int CMD_LSB = 3;
    localparam int CMD_W   = 3;
    localparam int RCMD_LSB = DW - 2;

    localparam logic [CMD_W-1:0] CMD_BANK_HIGH = 3'b001;

    localparam int IDX_STAT0  = 0;
    localparam int IDX_STAT1  = 1;
    localparam int IDX_VEC    = 2;
    localparam int IDX_MIR0   = 4;
    localparam int IDX_MIR1   = 5;
    localparam int IDX_XCTL   = 7;
    localparam int IDX_TXRX   = 8;
    localparam int IDX_MASTER = 9;
    localparam int IDX_BTC_HI = 13;
    localparam int MIRROR_BIT = 6;

    typedef logic [DW-1:0] byte_t;
    typedef logic [NREG-1:0][DW-1:0] regfile_t;

    typedef enum logic [1:0] {
        RC_NONE = 2'b00,
        RC_CHB  = 2'b01,
        RC_CHA  = 2'b10,
        RC_ALL  = 2'b11
    } rstcmd_e;

    function automatic logic is_stored(input logic [IDXW-1:0] idx);
        return ((idx >= 1) && (idx <= 7)) || ((idx >= 11) && (idx <= 14));
    endfunction
endpackage

// File: rtl/regptr_chan.sv
module regptr_chan
    import regptr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            acc_i,
    input  logic            wr_i,
    input  byte_t           wdata_i,
    output logic [IDXW-1:0] idx_o,
    output regfile_t        regs_o
);
    typedef struct packed {
        regfile_t regs;
        logic     hb;
    } chan_st_t;

    chan_st_t st_d, st_q;

    assign idx_o  = {st_q.hb, st_q.regs[0][PTRW-1:0]};
    assign regs_o = st_q.regs;

    always_comb begin
        st_d = st_q;
        if (acc_i) begin
            st_d.hb = 1'b0;
            if (wr_i) begin
                if (idx_o == '0) begin
                    st_d.regs[0] = wdata_i;
                    st_d.hb      = (wdata_i[CMD_LSB +: CMD_W] == CMD_BANK_HIGH);
                end else if (is_stored(idx_o)) begin
                    st_d.regs[idx_o] = wdata_i;
                end
            end
            if (idx_o != '0) begin
                st_d.regs[0][PTRW-1:0] = '0;
                if (st_q.hb) begin
                    st_d.regs[0][PTRW] = 1'b0;
                end
            end
        end
        if (clr_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/regptr_rdmux.sv
module regptr_rdmux
    import regptr_pkg::*;
(
    input  logic [IDXW-1:0] idx_i,
    input  logic            is_chb_i,
    input  logic            data_port_i,
    input  logic            mirror_i,
    input  byte_t           wr4_i,
    input  byte_t           wr5_i,
    input  byte_t           wr13_i,
    input  byte_t           rr0_i,
    input  byte_t           rr1_i,
    input  byte_t           vec_i,
    input  byte_t           rx_i,
    output byte_t           q_o
);
    always_comb begin
        q_o = '0;
        if (data_port_i) begin
            q_o = rx_i;
        end else begin
            case (int'(idx_i))
                IDX_STAT0:  q_o = rr0_i;
                IDX_STAT1:  q_o = rr1_i;
                IDX_VEC:    q_o = is_chb_i ? vec_i : '0;
                IDX_MIR0:   q_o = mirror_i ? wr4_i : rr0_i;
                IDX_MIR1:   q_o = mirror_i ? wr5_i : rr1_i;
                IDX_TXRX:   q_o = rx_i;
                IDX_BTC_HI: q_o = wr13_i;
                default:    q_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/regptr_top.sv
module regptr_top
    import regptr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs,
    input  logic                  rd,
    input  logic                  wr,
    input  logic                  chan_b,
    input  logic                  cd_sel,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    input  logic [NCH*DW-1:0]     rr0_i,
    input  logic [NCH*DW-1:0]     rr1_i,
    input  logic [DW-1:0]         vec_i,
    input  logic [NCH*DW-1:0]     rx_i,
    output logic [NCH*DW-1:0]     tx_o,
    output logic [NCH-1:0]        tx_load_o,
    output logic [NCH*NREG*DW-1:0] wregs_o,
    output logic [DW-1:0]         mctl_o
);
    localparam int CHB = 1;
    localparam int CHA = 0;

    typedef struct packed {
        byte_t                   mctl;
        logic [NCH-1:0][DW-1:0]  tx;
        logic [NCH-1:0]          txl;
    } top_st_t;

    top_st_t st_d, st_q;

    logic            acc_wr, acc_rd, ctl_acc, dat_acc;
    logic [NCH-1:0]  chan_acc;
    logic [NCH-1:0]  clr;
    logic [IDXW-1:0] idx   [NCH];
    regfile_t        regs  [NCH];
    logic [IDXW-1:0] sel_idx;
    regfile_t        sel_regs;
    byte_t           mux_q;
    rstcmd_e         rcmd;

    assign acc_wr  = cs & wr;
    assign acc_rd  = cs & rd & ~wr;
    assign ctl_acc = (acc_wr | acc_rd) & ~cd_sel;
    assign dat_acc = (acc_wr | acc_rd) & cd_sel;

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
            assign chan_acc[ch] = ctl_acc & (int'(chan_b) == ch);
            regptr_chan u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr_i   (clr[ch]),
                .acc_i   (chan_acc[ch]),
                .wr_i    (acc_wr),
                .wdata_i (wdata),
                .idx_o   (idx[ch]),
                .regs_o  (regs[ch])
            );
            assign wregs_o[ch*NREG*DW +: NREG*DW] = regs[ch];
            assign tx_o[ch*DW +: DW]              = st_q.tx[ch];
        end
    endgenerate

    assign sel_idx  = idx[chan_b];
    assign sel_regs = regs[chan_b];
    assign rcmd     = rstcmd_e'(wdata[RCMD_LSB +: 2]);

    regptr_rdmux u_rdmux (
        .idx_i       (sel_idx),
        .is_chb_i    (chan_b),
        .data_port_i (cd_sel),
        .mirror_i    (sel_regs[IDX_XCTL][MIRROR_BIT]),
        .wr4_i       (sel_regs[IDX_MIR0]),
        .wr5_i       (sel_regs[IDX_MIR1]),
        .wr13_i      (sel_regs[IDX_BTC_HI]),
        .rr0_i       (rr0_i[chan_b*DW +: DW]),
        .rr1_i       (rr1_i[chan_b*DW +: DW]),
        .vec_i       (vec_i),
        .rx_i        (rx_i[chan_b*DW +: DW]),
        .q_o         (mux_q)
    );

    assign rdata = acc_rd ? mux_q : '0;

    always_comb begin
        st_d     = st_q;
        st_d.txl = '0;
        clr      = '0;
        if (acc_wr && (dat_acc || (ctl_acc && int'(sel_idx) == IDX_TXRX))) begin
            st_d.tx[chan_b]  = wdata;
            st_d.txl[chan_b] = 1'b1;
        end
        if (acc_wr && ctl_acc && int'(sel_idx) == IDX_MASTER) begin
            st_d.mctl = wdata;
            case (rcmd)
                RC_CHB: clr[CHB] = 1'b1;
                RC_CHA: clr[CHA] = 1'b1;
                RC_ALL: begin
                    clr     = '1;
                    st_d.tx = '0;
                end
                default: clr = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_load_o = st_q.txl;
    assign mctl_o    = st_q.mctl;
endmodule

// File: rtl/regptr_chk.sv
module regptr_chk
    import regptr_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cs,
    input logic                   rd,
    input logic                   wr,
    input logic                   chan_b,
    input logic                   cd_sel,
    input logic [DW-1:0]          wdata,
    input logic [DW-1:0]          rdata,
    input logic [NCH*DW-1:0]      rx_i,
    input logic [NCH*DW-1:0]      tx_o,
    input logic [NCH-1:0]         tx_load_o,
    input logic [NCH*NREG*DW-1:0] wregs_o
);
    // R1
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd && !wr) |-> rdata == '0);

    // R7
    dat_rd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && !wr && cd_sel && !chan_b) |-> rdata == rx_i[DW-1:0]);

    // R7
    dat_wr_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && cd_sel && !chan_b) |=> (tx_load_o[0] && tx_o[DW-1:0] == $past(wdata)));

    // R7
    tx_load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_load_o));

    // R7
    dat_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && (rd || wr) && cd_sel) |=> $stable(wregs_o[DW-1:0]) && $stable(wregs_o[NREG*DW +: DW]));

    // R4
    ptr_clear_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && (rd || wr) && !cd_sel && !chan_b && wregs_o[2:0] != 3'b000) |=> wregs_o[2:0] == 3'b000);

    // R4
    ptr_clear_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && (rd || wr) && !cd_sel && chan_b && wregs_o[NREG*DW +: 3] != 3'b000) |=> wregs_o[NREG*DW +: 3] == 3'b000);
endmodule

bind regptr_top regptr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .rd        (rd),
    .wr        (wr),
    .chan_b    (chan_b),
    .cd_sel    (cd_sel),
    .wdata     (wdata),
    .rdata     (rdata),
    .rx_i      (rx_i),
    .tx_o      (tx_o),
    .tx_load_o (tx_load_o),
    .wregs_o   (wregs_o)
);

// File: tb/regptr_top_tb.sv
module regptr_top_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs = 1'b0, rd = 1'b0, wr = 1'b0, chan_b = 1'b0, cd_sel = 1'b0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic [15:0]  rr0_i = 16'hB0A0;
    logic [15:0]  rr1_i = 16'hB1A1;
    logic [7:0]   vec_i = 8'h77;
    logic [15:0]  rx_i  = 16'hCBCA;
    logic [15:0]  tx_o;
    logic [1:0]   tx_load_o;
    logic [255:0] wregs_o;
    logic [7:0]   mctl_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regptr_top u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .chan_b(chan_b),
        .cd_sel(cd_sel), .wdata(wdata), .rdata(rdata), .rr0_i(rr0_i), .rr1_i(rr1_i),
        .vec_i(vec_i), .rx_i(rx_i), .tx_o(tx_o), .tx_load_o(tx_load_o),
        .wregs_o(wregs_o), .mctl_o(mctl_o)
    );

    function automatic logic [7:0] slot(input int ch, input int idx);
        return wregs_o[ch*128 + idx*8 +: 8];
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic ch, input logic dat, input logic w, input logic [7:0] d,
                       output logic [7:0] q);
        @(negedge clk);
        cs = 1'b1; chan_b = ch; cd_sel = dat; wr = w; rd = ~w; wdata = d;
        #1 q = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0; wr = 1'b0;
        #1;
    endtask

    task automatic cwr(input logic ch, input logic [7:0] d);
        logic [7:0] q;
        bus(ch, 1'b0, 1'b1, d, q);
    endtask

    task automatic crd(input logic ch, output logic [7:0] q);
        bus(ch, 1'b0, 1'b0, 8'h00, q);
    endtask

    task automatic setreg(input logic ch, input int idx, input logic [7:0] d);
        if (idx >= 8) cwr(ch, 8'h08 | 8'(idx - 8));
        else          cwr(ch, 8'(idx));
        cwr(ch, d);
    endtask

    task automatic getreg(input logic ch, input int idx, output logic [7:0] q);
        if (idx >= 8) cwr(ch, 8'h08 | 8'(idx - 8));
        else if (idx != 0) cwr(ch, 8'(idx));
        crd(ch, q);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset;
        do_reset();
        chk("R11 wregs zero", 16'(wregs_o != '0), 16'h0);
        chk("R11 mctl zero", 16'(mctl_o), 16'h0);
        chk("R11 tx zero", tx_o, 16'h0);
        chk("R1 rdata idle", 16'(rdata), 16'h0);
    endtask

    task automatic t_store;
        setreg(1'b0, 3, 8'h5A);
        chk("R2 R8 A slot3", 16'(slot(0, 3)), 16'h5A);
        chk("R4 A ptr back to 0", 16'(slot(0, 0)), 16'h00);
        setreg(1'b1, 12, 8'h34);
        chk("R3 B slot12 via bank high", 16'(slot(1, 12)), 16'h34);
        chk("R4 B wr0 cleared incl bit3", 16'(slot(1, 0)), 16'h00);
        chk("R3 A slot12 untouched", 16'(slot(0, 12)), 16'h00);
        cwr(1'b0, 8'h10);
        chk("R2 wr0 stored whole", 16'(slot(0, 0)), 16'h10);
        cwr(1'b0, 8'h00);
    endtask

    task automatic t_reads;
        logic [7:0] q;
        getreg(1'b0, 0, q); chk("R5 A idx0", 16'(q), 16'hA0);
        getreg(1'b1, 1, q); chk("R5 B idx1", 16'(q), 16'hB1);
        getreg(1'b0, 2, q); chk("R5 A idx2 zero", 16'(q), 16'h00);
        getreg(1'b1, 2, q); chk("R5 B idx2 vector", 16'(q), 16'h77);
        getreg(1'b0, 3, q); chk("R5 A idx3 zero", 16'(q), 16'h00);
        crd(1'b0, q);       chk("R4 read returns to idx0", 16'(q), 16'hA0);
    endtask

    task automatic t_mirror;
        logic [7:0] q;
        setreg(1'b0, 4, 8'h44);
        setreg(1'b0, 5, 8'h55);
        getreg(1'b0, 4, q); chk("R6 idx4 status", 16'(q), 16'hA0);
        getreg(1'b0, 5, q); chk("R6 idx5 status", 16'(q), 16'hA1);
        setreg(1'b0, 7, 8'h40);
        getreg(1'b0, 4, q); chk("R6 idx4 mirror", 16'(q), 16'h44);
        getreg(1'b0, 5, q); chk("R6 idx5 mirror", 16'(q), 16'h55);
    endtask

    task automatic t_bank_high;
        logic [7:0] q;
        setreg(1'b0, 13, 8'h9C);
        getreg(1'b0, 13, q); chk("R5 idx13 readback", 16'(q), 16'h9C);
        cwr(1'b0, 8'h08);
        crd(1'b0, q); chk("R3 R7 hb read idx8 rx", 16'(q), 16'hCA);
        crd(1'b0, q); chk("R3 one-shot back to idx0", 16'(q), 16'hA0);
        cwr(1'b0, 8'h0B);
        bus(1'b0, 1'b1, 1'b0, 8'h00, q); chk("R7 data read rx", 16'(q), 16'hCA);
        cwr(1'b0, 8'h21);
        chk("R3 hb survives data access", 16'(slot(0, 11)), 16'h21);
        cwr(1'b0, 8'h08);
        cwr(1'b1, 8'h00);
        cwr(1'b0, 8'h66);
        chk("R3 hb not leaked by other chan", 16'(tx_o[7:0]), 16'h66);
        getreg(1'b1, 10, q); chk("R5 idx10 zero", 16'(q), 16'h00);
    endtask

    task automatic t_tx;
        logic [7:0] q;
        bus(1'b1, 1'b1, 1'b1, 8'h3C, q);
        chk("R7 data write load B", 16'(tx_load_o), 16'h2);
        chk("R7 data write byte B", 16'(tx_o[15:8]), 16'h3C);
        @(negedge clk); #1;
        chk("R7 load pulse one cycle", 16'(tx_load_o), 16'h0);
        setreg(1'b0, 8, 8'hE1);
        chk("R7 ctl idx8 load A", 16'(tx_load_o), 16'h1);
        chk("R7 ctl idx8 byte A", 16'(tx_o[7:0]), 16'hE1);
    endtask

    task automatic t_discard;
        setreg(1'b0, 10, 8'hFF);
        chk("R8 idx10 discarded", 16'(slot(0, 10)), 16'h00);
        setreg(1'b0, 15, 8'hFF);
        chk("R8 idx15 discarded", 16'(slot(0, 15)), 16'h00);
        setreg(1'b1, 14, 8'hE3);
        chk("R8 idx14 stored", 16'(slot(1, 14)), 16'hE3);
        setreg(1'b1, 11, 8'h5B);
        chk("R8 idx11 stored", 16'(slot(1, 11)), 16'h5B);
    endtask

    task automatic t_reg9;
        setreg(1'b0, 1, 8'h11);
        setreg(1'b1, 1, 8'h22);
        setreg(1'b0, 9, 8'h41);
        chk("R9 mctl stored", 16'(mctl_o), 16'h41);
        chk("R9 slot9 stays zero", 16'(slot(0, 9)), 16'h00);
        chk("R10 cmd01 clears B", 16'(slot(1, 1)), 16'h00);
        chk("R10 cmd01 keeps A", 16'(slot(0, 1)), 16'h11);
        setreg(1'b1, 9, 8'h02);
        chk("R10 cmd00 keeps A", 16'(slot(0, 1)), 16'h11);
        chk("R9 mctl from B", 16'(mctl_o), 16'h02);
        setreg(1'b1, 9, 8'h80);
        chk("R10 cmd10 clears A", 16'(slot(0, 1)), 16'h00);
        setreg(1'b0, 1, 8'h11);
        setreg(1'b1, 1, 8'h22);
        cwr(1'b1, 8'h03);
        setreg(1'b0, 9, 8'hC5);
        chk("R10 cmd11 clears A", 16'(slot(0, 1)), 16'h00);
        chk("R10 cmd11 clears B", 16'(slot(1, 1)), 16'h00);
        chk("R10 cmd11 clears B ptr", 16'(slot(1, 0)), 16'h00);
        chk("R10 cmd11 clears tx", tx_o, 16'h0000);
        chk("R10 mctl keeps byte", 16'(mctl_o), 16'hC5);
        do_reset();
        chk("R11 hw reset mctl", 16'(mctl_o), 16'h00);
    endtask

    initial begin
        t_reset();
        t_store();
        t_reads();
        t_mirror();
        t_bank_high();
        t_tx();
        t_discard();
        t_reg9();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule